// File: doc/BRIEF.md
# Glitch-Free Smart Card Clock Generator

This block makes the clock that goes out to a smart card. While a card session runs, the card clock is the reference clock divided by two or by four, chosen by one select bit. When the power-down bit is set, the block drives one of three idle behaviours chosen by two sleep bits: a steady low, a steady high, or half the rate of the internal oscillator. A card-clock enable from the activation sequencer is the master gate. While it is low, the output settles low.

The block has three output sources. Two are dividers: one clocked by the reference and one by the oscillator. The third is a level holder clocked by the oscillator. Each source is a flop in its own clock domain, and the card clock is the OR of those flops.

A source starts only after every other source has reported itself idle through a two-flop synchroniser. A running source stops only at the end of a complete period, with its output low. Each divider begins with a full low half followed by a full high half. A new divide ratio is loaded only at a period boundary. Together these rules mean that no shortened pulse reaches the card.

Top module: `card_clk_gen`

## Requirements
- R1: While `rst` is high, and afterwards until a source is enabled, `card_clk` is low.
- R2: While `clk_en` is low, `card_clk` settles low and stays low, whatever `pwr_down`, `sleep_sel` and `slow_sel` are.
- R3: With `clk_en`=1 and `pwr_down`=0, `card_clk` runs at 50% duty. Its period is 2 reference periods when `slow_sel`=0 and 4 reference periods when `slow_sel`=1.
- R4: With `pwr_down`=0, the value of `sleep_sel` has no effect on `card_clk`.
- R5: With `clk_en`=1 and `pwr_down`=1, `sleep_sel`=2'b00 or 2'b11 holds `card_clk` low, and `sleep_sel`=2'b01 holds it high.
- R6: With `clk_en`=1, `pwr_down`=1 and `sleep_sel`=2'b10, `card_clk` runs at 50% duty with a period of 2 oscillator periods.
- R7: When a divider source starts from idle, `card_clk` first stays low for one full half period and then gives a high pulse of full nominal width.
- R8: A change of `slow_sel` during a session takes effect only at a period boundary. Every high and every low phase lasts exactly one half period of either the old ratio or the new one.
- R9: Across all changes of ratio, source and mode, no high or low phase on `card_clk` is shorter than 45% of the shortest period in use. A source hands over only after it has finished its period with the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock that feeds the session divider |
| osc_clk | input | 1 | Internal oscillator clock that feeds the sleep divider and the level holder |
| rst | input | 1 | Synchronous active-high reset, sampled in both clock domains |
| clk_en | input | 1 | Card-clock enable from the activation sequencer |
| pwr_down | input | 1 | Selects the sleep behaviour instead of the session divider |
| sleep_sel | input | 2 | Sleep behaviour: 00 low, 01 high, 10 oscillator/2, 11 low |
| slow_sel | input | 1 | Session ratio: 0 divides by 2, 1 divides by 4 |
| card_clk | output | 1 | Clock driven to the card |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of a period. It only shows up when `slow_sel` toggles at intervals unrelated to the divided period. The stimulus flips `slow_sel` many times at irregular spacings of 13 to 17 ns while the session divider runs. A monitor times every high and low phase and accepts only 5 ns or 10 ns phases.

The oscillator runs at a period unrelated to the reference and with a phase offset. Because of this, the table walk moves the design through every pair of sources with their edges at arbitrary relative positions. A global minimum-width record then catches any runt pulse at a hand-over.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;

    localparam int HALF_W        = 2;
    localparam int REF_HALF_FAST = 1;
    localparam int REF_HALF_SLOW = 2;
    localparam int OSC_HALF      = 1;
    localparam int SYNC_STAGES   = 2;

    typedef enum logic [1:0] {
        SLP_LOW  = 2'b00,
        SLP_HIGH = 2'b01,
        SLP_OSC  = 2'b10,
        SLP_RSVD = 2'b11
    } sleep_mode_e;

    typedef struct packed {
        logic ref_run;
        logic osc_run;
        logic hold_hi;
    } ccg_req_t;

    function automatic ccg_req_t decode_req(input logic en, input logic pd,
                                            input sleep_mode_e mode);
        ccg_req_t r;
        r.ref_run = en && !pd;
        r.osc_run = en && pd && (mode == SLP_OSC);
        r.hold_hi = en && pd && (mode == SLP_HIGH);
        return r;
    endfunction

endpackage

// File: rtl/ccg_sync.sv
`timescale 1ns/1ps
module ccg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ccg_divider.sv
`timescale 1ns/1ps
module ccg_divider #(
    parameter int HALF_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              others_busy,
    input  logic [HALF_W-1:0] half_in,
    output logic              active,
    output logic              clk_out
);
    localparam int CNT_W = HALF_W + 1;

    logic [CNT_W-1:0]  cnt;
    logic [HALF_W-1:0] half_q;
    logic              clk_q;
    logic [CNT_W-1:0]  period_m1;
    logic [CNT_W-1:0]  cnt_nx;
    logic              at_end;

    assign period_m1 = {half_q, 1'b0} - 1'b1;
    assign cnt_nx    = cnt + 1'b1;
    assign at_end    = (cnt == period_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
            half_q <= HALF_W'(1);
            clk_q  <= 1'b0;
        end else if (!active) begin
            clk_q <= 1'b0;
            if (req && !others_busy) begin
                active <= 1'b1;
                cnt    <= '0;
                half_q <= half_in;
            end
        end else if (at_end) begin
            clk_q <= 1'b0;
            cnt   <= '0;
            if (req) half_q <= half_in;
            else     active <= 1'b0;
        end else begin
            cnt   <= cnt_nx;
            clk_q <= (cnt_nx >= {1'b0, half_q});
        end
    end

    assign clk_out = clk_q;

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> !clk_q);                                   // R7
    AST_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> !clk_q);                                   // R9
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !active |-> !clk_q);                                         // R2
    AST_FULL_PHASE: assert property (@(posedge clk) disable iff (rst)
        (!$stable(clk_q) && half_q > HALF_W'(1)) |=> $stable(clk_q)); // R8
endmodule

// File: rtl/ccg_hold.sv
`timescale 1ns/1ps
module ccg_hold (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic others_busy,
    output logic level
);
    always_ff @(posedge clk) begin
        if (rst)         level <= 1'b0;
        else if (!level) level <= req && !others_busy;
        else             level <= req;
    end
endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen
    import ccg_pkg::*;
(
    input  logic       ref_clk,
    input  logic       osc_clk,
    input  logic       rst,
    input  logic       clk_en,
    input  logic       pwr_down,
    input  logic [1:0] sleep_sel,
    input  logic       slow_sel,
    output logic       card_clk
);
    ccg_req_t          req_raw;
    logic [1:0]        ref_ctl_s;
    logic [1:0]        osc_ctl_s;
    logic              ref_others_s;
    logic              osc_ref_busy_s;
    logic              ref_busy, ref_out;
    logic              osc_busy, osc_out;
    logic              hold_q;
    logic [HALF_W-1:0] ref_half;

    assign req_raw = decode_req(clk_en, pwr_down, sleep_mode_e'(sleep_sel));

    // reference domain
    ccg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_ref_ctl (
        .clk(ref_clk), .rst(rst),
        .d({req_raw.ref_run, slow_sel}), .q(ref_ctl_s));

    ccg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_ref_peer (
        .clk(ref_clk), .rst(rst),
        .d(osc_busy | hold_q), .q(ref_others_s));

    assign ref_half = ref_ctl_s[0] ? HALF_W'(REF_HALF_SLOW) : HALF_W'(REF_HALF_FAST);

    ccg_divider #(.HALF_W(HALF_W)) u_ref_div (
        .clk(ref_clk), .rst(rst), .req(ref_ctl_s[1]),
        .others_busy(ref_others_s), .half_in(ref_half),
        .active(ref_busy), .clk_out(ref_out));

    // oscillator domain
    ccg_sync #(.W(2), .STAGES(SYNC_STAGES)) u_osc_ctl (
        .clk(osc_clk), .rst(rst),
        .d({req_raw.osc_run, req_raw.hold_hi}), .q(osc_ctl_s));

    ccg_sync #(.W(1), .STAGES(SYNC_STAGES)) u_osc_peer (
        .clk(osc_clk), .rst(rst),
        .d(ref_busy), .q(osc_ref_busy_s));

    ccg_divider #(.HALF_W(HALF_W)) u_osc_div (
        .clk(osc_clk), .rst(rst), .req(osc_ctl_s[1]),
        .others_busy(osc_ref_busy_s | hold_q), .half_in(HALF_W'(OSC_HALF)),
        .active(osc_busy), .clk_out(osc_out));

    ccg_hold u_hold (
        .clk(osc_clk), .rst(rst), .req(osc_ctl_s[0]),
        .others_busy(osc_ref_busy_s | osc_busy), .level(hold_q));

    assign card_clk = ref_out | osc_out | hold_q;

    AST_SOLE_OSC_SOURCE: assert property (@(posedge osc_clk) disable iff (rst)
        !(osc_busy && hold_q));                                      // R9
    AST_HOLD_WAITS_REF: assert property (@(posedge osc_clk) disable iff (rst)
        $rose(hold_q) |-> !$past(osc_ref_busy_s));                   // R9
endmodule

// File: tb/card_clk_gen_bench.sv
`timescale 1ns/1ps
module card_clk_gen_bench;
    logic       ref_clk = 1'b0;
    logic       osc_clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_en = 1'b0;
    logic       pwr_down = 1'b0;
    logic [1:0] sleep_sel = 2'b00;
    logic       slow_sel = 1'b0;
    logic       card_clk;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    card_clk_gen u_card_clk_gen (
        .ref_clk(ref_clk), .osc_clk(osc_clk), .rst(rst), .clk_en(clk_en),
        .pwr_down(pwr_down), .sleep_sel(sleep_sel), .slow_sel(slow_sel),
        .card_clk(card_clk));

    always #2.5 ref_clk = ~ref_clk;             // 200 MHz
    initial begin
        #1.3;
        forever #4 osc_clk = ~osc_clk;          // 8 ns oscillator
    end

    // pulse monitor
    bit      mon_on = 0;
    bit      win_on = 0;
    bit      rise_seen = 0;
    int      edges = 0;
    int      odd_w = 0;
    realtime t_rise = 0, t_fall = 0, last_period = 0, last_hi = 0;
    realtime min_hi = 1.0e9, min_lo = 1.0e9;

    function automatic bit near(realtime a, realtime b);
        return (a > b - 0.3) && (a < b + 0.3);
    endfunction

    always @(posedge card_clk) if (mon_on) begin
        realtime lo;
        lo = $realtime - t_fall;
        if (lo < min_lo) min_lo = lo;
        if (win_on && !near(lo, 5.0) && !near(lo, 10.0)) odd_w++;
        if (rise_seen) last_period = $realtime - t_rise;
        rise_seen = 1;
        t_rise = $realtime;
        edges++;
    end

    always @(negedge card_clk) if (mon_on) begin
        last_hi = $realtime - t_rise;
        if (last_hi < min_hi) min_hi = last_hi;
        if (win_on && !near(last_hi, 5.0) && !near(last_hi, 10.0)) odd_w++;
        t_fall = $realtime;
    end

    task automatic check(input bit ok, input string tag,
                         input real act, input real exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0.2f expected=%0.2f", tag, act, exp);
        end
    endtask

    // fields: en, pd, mode[1:0], slow, kind[1:0] (0 low,1 high,2 toggle), period ns
    localparam int NV = 12;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 1'b0, 2'd0, 1'b0, 2'd2, 7'd10},  // R3 divide by 2
        {1'b1, 1'b0, 2'd0, 1'b1, 2'd2, 7'd20},  // R3 divide by 4
        {1'b1, 1'b0, 2'd1, 1'b0, 2'd2, 7'd10},  // R4 sleep bits ignored
        {1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 7'd0},   // R5 stop low
        {1'b1, 1'b1, 2'd1, 1'b1, 2'd1, 7'd0},   // R5 stop high
        {1'b1, 1'b1, 2'd2, 1'b0, 2'd2, 7'd16},  // R6 oscillator half rate
        {1'b1, 1'b1, 2'd3, 1'b1, 2'd0, 7'd0},   // R5 code 11 low
        {1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 7'd0},   // R2 enable low beats high
        {1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 7'd0},   // R2 enable low
        {1'b1, 1'b0, 2'd2, 1'b1, 2'd2, 7'd20},  // R4 divide by 4, mode ignored
        {1'b1, 1'b1, 2'd2, 1'b1, 2'd2, 7'd16},  // R6 from session to sleep
        {1'b1, 1'b0, 2'd0, 1'b0, 2'd2, 7'd10}   // R3 back to divide by 2
    };

    initial begin
        #100000;
        if (!finished) begin
            check(1'b0, "watchdog", 0.0, 1.0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        #41;
        check(card_clk == 1'b0, "R1 low during reset", real'(card_clk), 0.0);
        #60;
        rst = 1'b0;
        #1;
        mon_on = 1;
        t_fall = $realtime;
        #200;
        check(card_clk == 1'b0 && edges == 0, "R1 low after reset", real'(edges), 0.0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            int e0;
            logic [1:0] kind;
            real per;
            clk_en    = VEC[v][13];
            pwr_down  = VEC[v][12];
            sleep_sel = VEC[v][11:10];
            slow_sel  = VEC[v][9];
            kind      = VEC[v][8:7];
            per       = real'(VEC[v][6:0]);
            #301;
            e0 = edges;
            #200;
            if (kind == 2'd2) begin
                check(edges > e0 && near(last_period, per),
                      $sformatf("R3/R6 vec%0d period", v), last_period, per);
                check(near(last_hi, per / 2.0),
                      $sformatf("R3/R6 vec%0d duty", v), last_hi, per / 2.0);
            end else begin
                check(edges == e0, $sformatf("R5/R2 vec%0d static", v),
                      real'(edges - e0), 0.0);
                check(card_clk == kind[0], $sformatf("R5/R2 vec%0d level", v),
                      real'(card_clk), real'(kind[0]));
            end
        end

        // R8 irregular ratio changes mid-period
        clk_en = 1'b1; pwr_down = 1'b0; slow_sel = 1'b0;
        #200;
        win_on = 1;
        for (int i = 0; i < 40; i++) begin
            slow_sel = ~slow_sel;
            #(13 + (i % 5));
        end
        #100;
        win_on = 0;
        check(odd_w == 0, "R8 phases whole halves", real'(odd_w), 0.0);

        // R7 first pulse from idle
        clk_en = 1'b0;
        #300;
        slow_sel = 1'b1;
        #50;
        begin
            realtime t_on, t_r;
            t_on = $realtime;
            clk_en = 1'b1;
            @(posedge card_clk);
            t_r = $realtime;
            check((t_r - t_on) >= 10.0, "R7 full low half first", t_r - t_on, 10.0);
            @(negedge card_clk);
            check(near($realtime - t_r, 10.0), "R7 first high width",
                  $realtime - t_r, 10.0);
        end
        #200;
        check(near(last_period, 20.0), "R7 steady after start", last_period, 20.0);

        // R9 global minimum widths (45% of 10 ns)
        check(min_hi >= 4.5, "R9 min high width", min_hi, 4.5);
        check(min_lo >= 4.5, "R9 min low width", min_lo, 4.5);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule